// File: doc/BRIEF.md
# Quad-Port Byte-Masked RAM

A synchronous memory with two write ports and two read ports that share one clock and one clock enable. Each write port takes an address, a data word and one enable bit per byte lane, so it can store part of a word. Each read port takes an address and a read enable and returns a word on its own output, `q_a` or `q_b`. Every word holds zero after reset.

The two read ports handle a collision in different ways. If a read and a write hit the same word in the same cycle, read port A returns the word as it will be after the write, and read port B returns the word as it was before the write. A read port whose read enable is low can drive zeros instead of holding its last value. Each output can have its own extra output register, which adds one cycle of latency. Each output can also be cleared, either synchronously or asynchronously. The write inputs and the read addresses can be registered as well. All of these options are set by parameters.

Top module: `quad_port_ram`

## Requirements
- R1: Byte-enable bit i of a write port covers data bits [i*LANE_W +: LANE_W]. A lane whose bit is 0 keeps its stored value. A lane whose bit is 1 takes the write data. A write port with all enable bits at 0 writes nothing.
- R2: If both write ports hit the same address in one cycle, a lane enabled by both ports takes port A's data. A lane enabled by only one port takes that port's data.
- R3: If read port A reads the address being written in the same cycle, it returns the word after the write, byte enables applied.
- R4: If read port B reads the address being written in the same cycle, it returns the word stored before the write.
- R5: With no output register, the read data appears one clock after the address is sampled. With the output register on (the default for port A), it appears two clocks after.
- R6: With FORCE_ZERO set and the clock enable high, a read port whose read enable is 0 loads all zeros into its read register.
- R7: While the clock enable is high, the synchronous clear sets each output selected for it to zero at the next edge. While the clock enable is low, the synchronous clear has no effect.
- R8: The asynchronous clear drives each output selected for it to zero at once, without waiting for a clock edge.
- R9: While the clock enable is low, no write takes place and no register changes, except through the asynchronous clear.
- R10: After reset, both outputs are zero and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for all registers and writes |
| wa_addr | input | $clog2(DEPTH) | Write port A address |
| wa_data | input | DATA_W | Write port A data |
| wa_be | input | DATA_W/LANE_W | Write port A lane enables |
| wb_addr | input | $clog2(DEPTH) | Write port B address |
| wb_data | input | DATA_W | Write port B data |
| wb_be | input | DATA_W/LANE_W | Write port B lane enables |
| ra_addr | input | $clog2(DEPTH) | Read port A address |
| ra_en | input | 1 | Read port A enable |
| rb_addr | input | $clog2(DEPTH) | Read port B address |
| rb_en | input | 1 | Read port B enable |
| aclr | input | 1 | Asynchronous output clear |
| sclr | input | 1 | Synchronous output clear |
| q_a | output | DATA_W | Read port A data |
| q_b | output | DATA_W | Read port B data |

## Verification
The assertions assume two things about the inputs. First, `aclr` changes only away from the rising clock edge. Second, `rst_n` is released in step with the clock. The bench meets both by driving every input on the falling edge, including the single directed pulse of the asynchronous clear. The random phase keeps write and read addresses in a four-word window, so same-address writes and read-during-write collisions happen often. The clock enable and the synchronous clear are toggled at random so that freezes and clears fall on collision cycles.

// File: rtl/qpr_pkg.sv
package qpr_pkg;
  // Where a read port takes its data from when a write to the same word lands in the same cycle
  typedef enum logic {RDW_NEW = 1'b0, RDW_OLD = 1'b1} rdw_mode_e;

  function automatic bit lane_ok(input int w);
    return (w == 5) || (w == 8) || (w == 9) || (w == 10);
  endfunction
endpackage

// File: rtl/qpr_in_reg.sv
module qpr_in_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r, q_nxt;
      always_comb q_nxt = ce ? d : q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
      assign q = q_r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/qpr_array.sv
module qpr_array #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [AW-1:0]     wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic [LANES-1:0]  wa_be,
  input  logic [AW-1:0]     wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [LANES-1:0]  wb_be,
  output logic [DATA_W-1:0] mem_q   [DEPTH],
  output logic [DATA_W-1:0] mem_nxt [DEPTH]
);
  // Port B lanes are applied first, then port A lanes overwrite them, so port A wins on shared lanes
  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_nxt[i] = mem_q[i];
    if (ce) begin
      for (int l = 0; l < LANES; l++)
        if (wb_be[l]) mem_nxt[wb_addr][l*LANE_W +: LANE_W] = wb_data[l*LANE_W +: LANE_W];
      for (int l = 0; l < LANES; l++)
        if (wa_be[l]) mem_nxt[wa_addr][l*LANE_W +: LANE_W] = wa_data[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_nxt[i];
    end
  end

  AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && (|wa_be) && !wa_be[0] && !(wb_be[0] && (wb_addr == wa_addr)))
    |=> (mem_q[$past(wa_addr)][LANE_W-1:0] == $past(mem_q[wa_addr][LANE_W-1:0]))); // R1

  AST_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wa_be[0] && wb_be[0] && (wa_addr == wb_addr))
    |=> (mem_q[$past(wa_addr)][LANE_W-1:0] == $past(wa_data[LANE_W-1:0]))); // R2
endmodule

// File: rtl/qpr_rd_port.sv
module qpr_rd_port
  import qpr_pkg::*;
#(
  parameter int        DEPTH      = 16,
  parameter int        DATA_W     = 32,
  parameter rdw_mode_e MODE       = RDW_NEW,
  parameter bit        FORCE_ZERO = 1'b1,
  localparam int       AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [AW-1:0]     addr,
  input  logic              ren,
  input  logic              sclr_i,
  input  logic              aclr_i,
  input  logic [DATA_W-1:0] mem_q   [DEPTH],
  input  logic [DATA_W-1:0] mem_nxt [DEPTH],
  output logic [DATA_W-1:0] data_q
);
  logic [DATA_W-1:0] word_sel, data_nxt;

  always_comb begin
    word_sel = (MODE == RDW_NEW) ? mem_nxt[addr] : mem_q[addr];
    data_nxt = data_q;
    if (ce) begin
      if (sclr_i)          data_nxt = '0;
      else if (ren)        data_nxt = word_sel;
      else if (FORCE_ZERO) data_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge aclr_i) begin
    if (!rst_n)      data_q <= '0;
    else if (aclr_i) data_q <= '0;
    else             data_q <= data_nxt;
  end

  generate
    if (FORCE_ZERO) begin : g_fz_chk
      AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !ren) |=> (data_q == '0)); // R6
    end
  endgenerate

  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(data_q) || (data_q == '0))); // R9
endmodule

// File: rtl/qpr_out_reg.sv
module qpr_out_reg #(
  parameter int DATA_W = 32,
  parameter bit EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclr_i,
  input  logic              aclr_i,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [DATA_W-1:0] q_r, q_nxt;
      always_comb begin
        q_nxt = q_r;
        if (ce) q_nxt = sclr_i ? '0 : d;
      end
      always_ff @(posedge clk or negedge rst_n or posedge aclr_i) begin
        if (!rst_n)      q_r <= '0;
        else if (aclr_i) q_r <= '0;
        else             q_r <= q_nxt;
      end
      assign q = q_r;

      AST_SCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && sclr_i) |=> (q == '0)); // R7
      AST_SCLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !aclr_i) |=> ($stable(q) || (q == '0))); // R9
      AST_ACLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        aclr_i |-> (q == '0)); // R8
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
  import qpr_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 32,
  parameter int LANE_W     = 8,
  parameter bit REG_WR     = 1'b0,
  parameter bit REG_RA     = 1'b0,
  parameter bit REG_QA     = 1'b1,
  parameter bit REG_QB     = 1'b0,
  parameter bit FORCE_ZERO = 1'b1,
  parameter bit ACLR_QA    = 1'b1,
  parameter bit ACLR_QB    = 1'b1,
  parameter bit SCLR_QA    = 1'b1,
  parameter bit SCLR_QB    = 1'b1,
  localparam int AW        = $clog2(DEPTH),
  localparam int LANES     = DATA_W / LANE_W,
  localparam int WBUS      = AW + DATA_W + LANES,
  localparam int RBUS      = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [AW-1:0]     wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic [LANES-1:0]  wa_be,
  input  logic [AW-1:0]     wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [LANES-1:0]  wb_be,
  input  logic [AW-1:0]     ra_addr,
  input  logic              ra_en,
  input  logic [AW-1:0]     rb_addr,
  input  logic              rb_en,
  input  logic              aclr,
  input  logic              sclr,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b
);
  generate
    if (!lane_ok(LANE_W) || (DATA_W % LANE_W) != 0) begin : g_bad_cfg
      $error("quad_port_ram: lane width must be 5, 8, 9 or 10 and divide DATA_W");
    end
  endgenerate

  // Optional input registers
  logic [AW-1:0]     wa_addr_s, wb_addr_s, ra_addr_s, rb_addr_s;
  logic [DATA_W-1:0] wa_data_s, wb_data_s;
  logic [LANES-1:0]  wa_be_s, wb_be_s;
  logic              ra_en_s, rb_en_s;

  qpr_in_reg #(.W(WBUS), .EN(REG_WR)) u_wa_in (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .d({wa_addr, wa_data, wa_be}), .q({wa_addr_s, wa_data_s, wa_be_s}));
  qpr_in_reg #(.W(WBUS), .EN(REG_WR)) u_wb_in (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .d({wb_addr, wb_data, wb_be}), .q({wb_addr_s, wb_data_s, wb_be_s}));
  qpr_in_reg #(.W(RBUS), .EN(REG_RA)) u_ra_in (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .d({ra_addr, ra_en}), .q({ra_addr_s, ra_en_s}));
  qpr_in_reg #(.W(RBUS), .EN(REG_RA)) u_rb_in (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .d({rb_addr, rb_en}), .q({rb_addr_s, rb_en_s}));

  // Storage
  logic [DATA_W-1:0] mem_q   [DEPTH];
  logic [DATA_W-1:0] mem_nxt [DEPTH];

  qpr_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .wa_addr(wa_addr_s), .wa_data(wa_data_s), .wa_be(wa_be_s),
    .wb_addr(wb_addr_s), .wb_data(wb_data_s), .wb_be(wb_be_s),
    .mem_q(mem_q), .mem_nxt(mem_nxt));

  // Clears go to whichever register drives the output
  logic sclr_a, aclr_a, sclr_b, aclr_b;
  assign sclr_a = sclr & SCLR_QA;
  assign aclr_a = aclr & ACLR_QA;
  assign sclr_b = sclr & SCLR_QB;
  assign aclr_b = aclr & ACLR_QB;

  logic [DATA_W-1:0] rd_a, rd_b;

  qpr_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .MODE(RDW_NEW), .FORCE_ZERO(FORCE_ZERO)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(ra_addr_s), .ren(ra_en_s),
    .sclr_i(REG_QA ? 1'b0 : sclr_a), .aclr_i(REG_QA ? 1'b0 : aclr_a),
    .mem_q(mem_q), .mem_nxt(mem_nxt), .data_q(rd_a));
  qpr_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .MODE(RDW_OLD), .FORCE_ZERO(FORCE_ZERO)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .ce(ce), .addr(rb_addr_s), .ren(rb_en_s),
    .sclr_i(REG_QB ? 1'b0 : sclr_b), .aclr_i(REG_QB ? 1'b0 : aclr_b),
    .mem_q(mem_q), .mem_nxt(mem_nxt), .data_q(rd_b));

  qpr_out_reg #(.DATA_W(DATA_W), .EN(REG_QA)) u_out_a (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .sclr_i(REG_QA ? sclr_a : 1'b0), .aclr_i(REG_QA ? aclr_a : 1'b0),
    .d(rd_a), .q(q_a));
  qpr_out_reg #(.DATA_W(DATA_W), .EN(REG_QB)) u_out_b (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .sclr_i(REG_QB ? sclr_b : 1'b0), .aclr_i(REG_QB ? aclr_b : 1'b0),
    .d(rd_b), .q(q_b));
endmodule

// File: tb/tb_quad_port_ram.sv
module tb_quad_port_ram;
  localparam int DEPTH = 16, DW = 32, LW = 8, AW = 4, LN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, ra_en = 1'b0, rb_en = 1'b0, aclr = 1'b0, sclr = 1'b0;
  logic [AW-1:0] wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [DW-1:0] wa_data = '0, wb_data = '0;
  logic [LN-1:0] wa_be = '0, wb_be = '0;
  logic [DW-1:0] q_a, q_b;

  int checks = 0, errors = 0;
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] m_ca, m_qa, m_cb;

  always #5 clk = ~clk;

  quad_port_ram #(.DEPTH(DEPTH), .DATA_W(DW), .LANE_W(LW), .REG_WR(1'b0), .REG_RA(1'b0),
    .REG_QA(1'b1), .REG_QB(1'b0), .FORCE_ZERO(1'b1), .ACLR_QA(1'b1), .ACLR_QB(1'b1),
    .SCLR_QA(1'b1), .SCLR_QB(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .wa_addr(wa_addr), .wa_data(wa_data), .wa_be(wa_be),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be),
    .ra_addr(ra_addr), .ra_en(ra_en), .rb_addr(rb_addr), .rb_en(rb_en),
    .aclr(aclr), .sclr(sclr), .q_a(q_a), .q_b(q_b));

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [LN-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LN; l++) if (be[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [DW-1:0] nm [DEPTH];
    if (!ce) return;
    for (int i = 0; i < DEPTH; i++) nm[i] = mm[i];
    nm[wb_addr] = merge(nm[wb_addr], wb_data, wb_be);
    nm[wa_addr] = merge(nm[wa_addr], wa_data, wa_be);
    m_qa = sclr ? '0 : m_ca;
    m_ca = ra_en ? nm[ra_addr] : '0;
    m_cb = sclr ? '0 : (rb_en ? mm[rb_addr] : '0);
    for (int i = 0; i < DEPTH; i++) mm[i] = nm[i];
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " q_a"}, q_a, m_qa);
    check({tag, " q_b"}, q_b, m_cb);
  endtask

  task automatic idle();
    ce = 1'b1; sclr = 1'b0; wa_be = '0; wb_be = '0; ra_en = 1'b0; rb_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    m_ca = '0; m_qa = '0; m_cb = '0;
    repeat (3) @(negedge clk);
    check("R10 reset q_a", q_a, '0);
    check("R10 reset q_b", q_b, '0);
    rst_n = 1'b1;
    idle();
    // R10: fresh words read zero
    ra_en = 1'b1; rb_en = 1'b1; ra_addr = 4'd5; rb_addr = 4'd11; tick("R10");
    tick("R10");
    // R1: full write then masked write
    idle(); wa_addr = 4'd3; wa_data = 32'hAABBCCDD; wa_be = 4'b1111; tick("R1");
    idle(); wb_addr = 4'd3; wb_data = 32'h11223344; wb_be = 4'b0101; tick("R1");
    idle(); rb_en = 1'b1; rb_addr = 4'd3; tick("R1");
    check("R1 merged word", q_b, 32'hAA22CC44);
    // R2: both ports same address
    idle(); wa_addr = 4'd7; wb_addr = 4'd7; wa_data = 32'h01020304; wb_data = 32'hF0E0D0C0;
    wa_be = 4'b0011; wb_be = 4'b0110; tick("R2");
    idle(); rb_en = 1'b1; rb_addr = 4'd7; tick("R2");
    check("R2 port A wins", q_b, 32'h00E00304);
    // R3/R4: read during write on address 3 (holds AA22CC44)
    idle(); wa_addr = 4'd3; wa_data = 32'h55667788; wa_be = 4'b1001;
    ra_en = 1'b1; rb_en = 1'b1; ra_addr = 4'd3; rb_addr = 4'd3; tick("R4");
    check("R4 old data", q_b, 32'hAA22CC44);
    idle(); tick("R3");
    check("R3 new data", q_a, 32'h5522CC88);
    // R5: latency, port B one clock, port A two clocks
    idle(); tick("R5");
    ra_en = 1'b1; rb_en = 1'b1; ra_addr = 4'd7; rb_addr = 4'd7; tick("R5");
    check("R5 q_b after one", q_b, 32'h00E00304);
    check("R5 q_a not yet", q_a, 32'h0);
    tick("R5");
    check("R5 q_a after two", q_a, 32'h00E00304);
    // R6: read enable low forces zero
    ra_en = 1'b0; rb_en = 1'b0; tick("R6");
    check("R6 q_b zero", q_b, 32'h0);
    tick("R6");
    check("R6 q_a zero", q_a, 32'h0);
    // R9: freeze with clock enable low
    idle(); ra_en = 1'b1; rb_en = 1'b1; ra_addr = 4'd3; rb_addr = 4'd3; tick("R9"); tick("R9");
    ce = 1'b0; wa_addr = 4'd3; wa_data = 32'h0; wa_be = 4'b1111; rb_addr = 4'd7;
    tick("R9"); tick("R9");
    check("R9 q_b held", q_b, 32'h5522CC88);
    // R7: sclr ignored while ce low, acts when ce high
    sclr = 1'b1; tick("R7");
    check("R7 gated q_a", q_a, 32'h5522CC88);
    idle(); sclr = 1'b1; ra_en = 1'b1; rb_en = 1'b1; ra_addr = 4'd3; rb_addr = 4'd3; tick("R7");
    check("R7 q_a cleared", q_a, 32'h0);
    check("R7 q_b cleared", q_b, 32'h0);
    sclr = 1'b0; tick("R9"); tick("R9");
    check("R9 no write", q_a, 32'h5522CC88);
    // R8: asynchronous clear takes effect between edges
    aclr = 1'b1; #2;
    m_qa = '0; m_cb = '0;
    check("R8 q_a async", q_a, 32'h0);
    check("R8 q_b async", q_b, 32'h0);
    #1 aclr = 1'b0;
    tick("R8");
    // Random phase with collisions
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      ce      = ($urandom % 10) != 0;
      sclr    = ($urandom % 20) == 0;
      wa_addr = 4'($urandom % 4); wb_addr = 4'($urandom % 4);
      ra_addr = 4'($urandom % 4); rb_addr = 4'($urandom % 4);
      wa_data = $urandom; wb_data = $urandom;
      wa_be = 4'($urandom); wb_be = 4'($urandom);
      ra_en = ($urandom % 5) != 0; rb_en = ($urandom % 5) != 0;
      tick("R2/R3/R4 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule